// File: doc/BRIEF.md
# Partial-Reconfiguration Load Engine Register Block

This block is the hardware end of a data-load engine for partial reconfiguration. Host software reaches it through a flat map of 64-bit registers. Software uses them in a fixed sequence:

- It requests an engine reset and waits for the acknowledge.
- It picks a target region and raises a start request.
- It pushes 32-bit image words into an internal queue, pacing itself on a live count of free entries.
- It flags that all data has been pushed, then polls until the hardware drops the start request.

Words leave the queue on a valid/ready stream toward a configuration sink. The sink also sees the selected region. The sink's CRC, image-compatibility and generic operation faults come back as single-cycle pulses. Push-side faults are detected locally. All faults land in an error register, where each bit stays set until software writes a one to that bit.

Top module: `recfg_load_engine`

## Requirements
- R1: After reset the control and error registers read zero, the status free-entry count (bits 8:0) equals DEPTH, and the status busy bit (16) is 0.
- R2: Writing 1 to control bit 0 sets the acknowledge (control bit 4) one cycle later. While the request is held, the queue is emptied, start (bit 12) and complete (bit 13) are cleared, and the free count reads DEPTH. The acknowledge drops one cycle after software writes bit 0 back to 0.
- R3: Control bits 9:7 hold a 3-bit region number. It reads back and drives the `cfg_region` output.
- R4: A write to the data register (offset 0x18) while start is set consumes one free entry. Only its bits 31:0 are queued, and bits 63:32 are discarded.
- R5: Queued words leave on `cfg_word` in write order. A presented word holds steady until `cfg_ready` accepts it.
- R6: A data write that finds zero free entries is dropped and sets error bit 4.
- R7: A data write while start is clear, or after complete has been set, is dropped and sets error bit 3.
- R8: Once complete is set, start and complete stay set until the queue has drained. The cycle after the drain, both clear.
- R9: Pulses on `op_err_in`, `crc_err_in` and `incompat_err_in` set error bits 0, 1 and 2. Error bits stay set until a write to offset 0x20 carries a 1 in that bit position. A new fault in the same cycle as its clear wins.
- R10: Status bit 16 reads 1 while start is set or any error bit is set, and 0 otherwise. Status bits 22:20 mirror `ctrl_sts_in` and bits 27:24 mirror `host_sts_in`.
- R11: Offsets 0x0, 0xA8 and 0xB0 return the parameters HDR_VALUE, IFC_ID_HI and IFC_ID_LO. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 64 | Register read data (combinational) |
| cfg_valid | output | 1 | Queue head word is valid |
| cfg_ready | input | 1 | Sink accepts the head word |
| cfg_word | output | 32 | Queue head word |
| cfg_region | output | 3 | Selected target region |
| op_err_in | input | 1 | Operation fault pulse from the sink |
| crc_err_in | input | 1 | CRC fault pulse from the sink |
| incompat_err_in | input | 1 | Incompatible-image pulse from the sink |
| ctrl_sts_in | input | 3 | Controller state, shown in status |
| host_sts_in | input | 4 | Host-side state, shown in status |

## Verification
The bench fills the queue to exactly zero credits and pushes one word more. A design with an off-by-one on fullness would either lose the last legal word or accept the extra one, and the in-order drain would show it. Data writes before start and after complete are checked for being dropped and for setting the protocol bit; a design that gated only on start would let a late word in. The bench watches start while complete is set and the queue still holds data. A design that retired on the complete write alone would drop start early. The bench also clears an error bit in the same cycle that a new pulse of the same kind arrives; a clear-wins design would lose that fault.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
   // register byte offsets (fixed by the software sequence)
   localparam logic [7:0] OFS_HDR  = 8'h00;
   localparam logic [7:0] OFS_CTRL = 8'h08;
   localparam logic [7:0] OFS_STS  = 8'h10;
   localparam logic [7:0] OFS_DATA = 8'h18;
   localparam logic [7:0] OFS_ERR  = 8'h20;
   localparam logic [7:0] OFS_IDH  = 8'hA8;
   localparam logic [7:0] OFS_IDL  = 8'hB0;

   // control field positions
   localparam int CB_RST    = 0;
   localparam int CB_ACK    = 4;
   localparam int CB_RGN_LO = 7;
   localparam int CB_START  = 12;
   localparam int CB_DONE   = 13;
   localparam int RGN_W     = 3;

   // status field positions
   localparam int CREDIT_W   = 9;
   localparam int SB_BUSY    = 16;
   localparam int SB_CTRL_LO = 20;
   localparam int SB_HOST_LO = 24;

   // error bit positions
   localparam int ERR_W      = 5;
   localparam int EB_OP      = 0;
   localparam int EB_CRC     = 1;
   localparam int EB_INCOMP  = 2;
   localparam int EB_PROTO   = 3;
   localparam int EB_OVF     = 4;

   typedef struct packed {
      logic             rst_req;
      logic [RGN_W-1:0] region;
      logic             start;
      logic             done;
   } ctrl_wr_t;
endpackage

// File: rtl/recfg_fifo.sv
module recfg_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign head  = mem[rptr];

   always_ff @(posedge clk) begin
      if (push && !full && !flush) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push && !full)  wptr <= bump(wptr);
         if (pop && !empty)  rptr <= bump(rptr);
         count <= count + CW'(push && !full) - CW'(pop && !empty);
      end
   end
endmodule

// File: rtl/recfg_ctrl.sv
module recfg_ctrl
   import recfg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  ctrl_wr_t         wf,
   input  logic             fifo_empty,
   output logic             rst_req,
   output logic             rst_ack,
   output logic [RGN_W-1:0] region,
   output logic             start,
   output logic             done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         rst_ack <= 1'b0;
         region  <= '0;
         start   <= 1'b0;
         done    <= 1'b0;
      end else begin
         rst_ack <= rst_req;
         if (wr) begin
            rst_req <= wf.rst_req;
            region  <= wf.region;
         end
         if (rst_req) begin
            start <= 1'b0;
            done  <= 1'b0;
         end else if (start && done && fifo_empty) begin
            start <= 1'b0;
            done  <= 1'b0;
         end else if (wr) begin
            if (wf.start) start <= 1'b1;
            if (wf.done && (start || wf.start)) done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/recfg_errlog.sv
module recfg_errlog #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] err
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err[i] <= 1'b0;
         else        err[i] <= set[i] | (err[i] & ~clr[i]);
      end
   end
endmodule

// File: rtl/recfg_load_engine.sv
module recfg_load_engine
   import recfg_pkg::*;
#(
   parameter int          DEPTH     = 16,
   parameter logic [63:0] HDR_VALUE = 64'h1000_0000_0000_5A01,
   parameter logic [63:0] IFC_ID_HI = 64'hC0DE_0001_2345_6789,
   parameter logic [63:0] IFC_ID_LO = 64'hFEED_0002_ABCD_EF01
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [7:0]  reg_wr_addr,
   input  logic [63:0] reg_wr_data,
   input  logic [7:0]  reg_rd_addr,
   output logic [63:0] reg_rd_data,
   output logic        cfg_valid,
   input  logic        cfg_ready,
   output logic [31:0] cfg_word,
   output logic [2:0]  cfg_region,
   input  logic        op_err_in,
   input  logic        crc_err_in,
   input  logic        incompat_err_in,
   input  logic [2:0]  ctrl_sts_in,
   input  logic [3:0]  host_sts_in
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH >= (1 << CREDIT_W)) begin : g_bad_depth
      $error("DEPTH must lie in 2..511");
   end

   logic             rst_req, rst_ack, start_q, done_q;
   logic [RGN_W-1:0] region;
   logic             fifo_empty, fifo_full;
   logic [CW-1:0]    fifo_cnt;
   logic [CREDIT_W-1:0] credits;
   logic [ERR_W-1:0] err_q, err_set, err_clr;
   logic             ctrl_wr, data_wr, err_wr;
   logic             proto_viol, ovf_viol, push;
   ctrl_wr_t         wf;
   logic             unused_hi;

   assign ctrl_wr = reg_wr_en && (reg_wr_addr == OFS_CTRL);
   assign data_wr = reg_wr_en && (reg_wr_addr == OFS_DATA);
   assign err_wr  = reg_wr_en && (reg_wr_addr == OFS_ERR);

   assign wf.rst_req = reg_wr_data[CB_RST];
   assign wf.region  = reg_wr_data[CB_RGN_LO +: RGN_W];
   assign wf.start   = reg_wr_data[CB_START];
   assign wf.done    = reg_wr_data[CB_DONE];
   assign unused_hi  = ^reg_wr_data[63:32];

   recfg_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (ctrl_wr),
      .wf         (wf),
      .fifo_empty (fifo_empty),
      .rst_req    (rst_req),
      .rst_ack    (rst_ack),
      .region     (region),
      .start      (start_q),
      .done       (done_q)
   );

   assign proto_viol = data_wr && (!start_q || done_q || rst_req);
   assign ovf_viol   = data_wr && !proto_viol && fifo_full;
   assign push       = data_wr && !proto_viol && !fifo_full;

   recfg_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rst_req),
      .push      (push),
      .push_data (reg_wr_data[31:0]),
      .pop       (cfg_valid && cfg_ready),
      .head      (cfg_word),
      .empty     (fifo_empty),
      .full      (fifo_full),
      .count     (fifo_cnt)
   );

   assign cfg_valid  = !fifo_empty;
   assign cfg_region = region;
   assign credits    = CREDIT_W'(DEPTH) - CREDIT_W'(fifo_cnt);

   always_comb begin
      err_set            = '0;
      err_set[EB_OP]     = op_err_in;
      err_set[EB_CRC]    = crc_err_in;
      err_set[EB_INCOMP] = incompat_err_in;
      err_set[EB_PROTO]  = proto_viol;
      err_set[EB_OVF]    = ovf_viol;
      err_clr            = err_wr ? reg_wr_data[ERR_W-1:0] : '0;
   end

   recfg_errlog #(.W(ERR_W)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .clr   (err_clr),
      .err   (err_q)
   );

   always_comb begin
      reg_rd_data = '0;
      case (reg_rd_addr)
         OFS_HDR: reg_rd_data = HDR_VALUE;
         OFS_CTRL: begin
            reg_rd_data[CB_RST]                = rst_req;
            reg_rd_data[CB_ACK]                = rst_ack;
            reg_rd_data[CB_RGN_LO +: RGN_W]    = region;
            reg_rd_data[CB_START]              = start_q;
            reg_rd_data[CB_DONE]               = done_q;
         end
         OFS_STS: begin
            reg_rd_data[CREDIT_W-1:0]          = credits;
            reg_rd_data[SB_BUSY]               = start_q || (|err_q);
            reg_rd_data[SB_CTRL_LO +: 3]       = ctrl_sts_in;
            reg_rd_data[SB_HOST_LO +: 4]       = host_sts_in;
         end
         OFS_ERR: reg_rd_data[ERR_W-1:0] = err_q;
         OFS_IDH: reg_rd_data = IFC_ID_HI;
         OFS_IDL: reg_rd_data = IFC_ID_LO;
         default: reg_rd_data = '0;
      endcase
   end
endmodule

// File: rtl/recfg_load_engine_chk.sv
module recfg_load_engine_chk
   import recfg_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [CREDIT_W-1:0] credits,
   input logic                rst_req,
   input logic                rst_ack,
   input logic                start_q,
   input logic                fifo_empty,
   input logic [ERR_W-1:0]    err_q,
   input logic                cfg_valid,
   input logic                cfg_ready,
   input logic [31:0]         cfg_word,
   input logic                reg_wr_en,
   input logic [7:0]          reg_wr_addr,
   input logic [63:0]         reg_wr_data
);
   logic [ERR_W-1:0] clr_mask;
   assign clr_mask = (reg_wr_en && reg_wr_addr == OFS_ERR) ? reg_wr_data[ERR_W-1:0] : '0;

   // R4
   credit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      credits <= CREDIT_W'(DEPTH));

   // R2
   ack_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ack |-> (credits == CREDIT_W'(DEPTH)) && !start_q);

   // R5
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_ready && !rst_req) |=> (cfg_valid && $stable(cfg_word)));

   // R8
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_q) |-> $past(fifo_empty || rst_req));

   // R9
   sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~err_q) & $past(err_q) & ~$past(clr_mask)) == '0);
endmodule

bind recfg_load_engine recfg_load_engine_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .credits     (credits),
   .rst_req     (rst_req),
   .rst_ack     (rst_ack),
   .start_q     (start_q),
   .fifo_empty  (fifo_empty),
   .err_q       (err_q),
   .cfg_valid   (cfg_valid),
   .cfg_ready   (cfg_ready),
   .cfg_word    (cfg_word),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_addr (reg_wr_addr),
   .reg_wr_data (reg_wr_data)
);

// File: tb/recfg_load_engine_test.sv
`timescale 1ns/1ps
module recfg_load_engine_test;
   localparam int DEPTH = 16;
   localparam logic [63:0] HDRV = 64'h1000_0000_0000_5A01;
   localparam logic [63:0] IDH  = 64'hC0DE_0001_2345_6789;
   localparam logic [63:0] IDL  = 64'hFEED_0002_ABCD_EF01;
   localparam logic [7:0] A_HDR = 8'h00, A_CTRL = 8'h08, A_STS = 8'h10,
                          A_DATA = 8'h18, A_ERR = 8'h20, A_IDH = 8'hA8, A_IDL = 8'hB0;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_wr_addr = '0, reg_rd_addr = '0;
   logic [63:0] reg_wr_data = '0, reg_rd_data;
   logic        cfg_valid, cfg_ready = 1'b0;
   logic [31:0] cfg_word;
   logic [2:0]  cfg_region;
   logic        op_err_in = 1'b0, crc_err_in = 1'b0, incompat_err_in = 1'b0;
   logic [2:0]  ctrl_sts_in = 3'd5;
   logic [3:0]  host_sts_in = 4'd9;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   logic [31:0] exp_q[$];

   always #2.5 clk = ~clk;

   recfg_load_engine #(.DEPTH(DEPTH), .HDR_VALUE(HDRV), .IFC_ID_HI(IDH), .IFC_ID_LO(IDL)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
      .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_word(cfg_word), .cfg_region(cfg_region),
      .op_err_in(op_err_in), .crc_err_in(crc_err_in), .incompat_err_in(incompat_err_in),
      .ctrl_sts_in(ctrl_sts_in), .host_sts_in(host_sts_in));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_rd_addr = a;
      #1 d = reg_rd_data;
   endtask

   task automatic push_word(input logic [31:0] w, input logic [31:0] junk);
      wr(A_DATA, {junk, w});
      exp_q.push_back(w);
   endtask

   task automatic drain(input string tag);
      int n = exp_q.size();
      @(negedge clk);
      cfg_ready = 1'b1;
      for (int i = 0; i < n; i++) begin
         #1;
         check(tag, {63'd0, cfg_valid}, 64'd1);
         check(tag, {32'd0, cfg_word}, {32'd0, exp_q.pop_front()});
         @(negedge clk);
      end
      cfg_ready = 1'b0;
      #1 check(tag, {63'd0, cfg_valid}, 64'd0);
   endtask

   task automatic engine_reset();
      logic [63:0] d;
      wr(A_CTRL, 64'h1);
      rd(A_CTRL, d);
      check("R2 ack set", {63'd0, d[4]}, 64'd1);
      rd(A_STS, d);
      check("R2 credits full in reset", {55'd0, d[8:0]}, DEPTH);
      wr(A_CTRL, 64'h0);
      rd(A_CTRL, d);
      check("R2 ack cleared", {63'd0, d[4]}, 64'd0);
      exp_q.delete();
   endtask

   task automatic t_reset_state();
      logic [63:0] d;
      rd(A_CTRL, d); check("R1 ctrl", d, 64'd0);
      rd(A_ERR, d);  check("R1 err", d, 64'd0);
      rd(A_STS, d);
      check("R1 credits", {55'd0, d[8:0]}, DEPTH);
      check("R1 busy", {63'd0, d[16]}, 64'd0);
      check("R10 ctrl sts", {61'd0, d[22:20]}, 64'd5);
      check("R10 host sts", {60'd0, d[27:24]}, 64'd9);
   endtask

   task automatic t_push_drain();
      logic [63:0] d;
      engine_reset();
      wr(A_CTRL, 64'h1000 | (64'd5 << 7));
      rd(A_CTRL, d);
      check("R3 region rd", {61'd0, d[9:7]}, 64'd5);
      check("R3 region out", {61'd0, cfg_region}, 64'd5);
      rd(A_STS, d); check("R10 busy on start", {63'd0, d[16]}, 64'd1);
      push_word(32'hA1B2C3D4, 32'hFFFF_FFFF);
      push_word(32'h0000_1111, 32'h1234_5678);
      push_word(32'hDEAD_BEEF, 32'h0);
      rd(A_STS, d); check("R4 credits after 3", {55'd0, d[8:0]}, DEPTH - 3);
      #1 check("R5 valid held", {32'd0, cfg_word}, 64'hA1B2C3D4);
      drain("R5 order / R4 low half");
      rd(A_STS, d); check("R4 credits back", {55'd0, d[8:0]}, DEPTH);
   endtask

   task automatic t_overflow();
      logic [63:0] d;
      for (int i = 0; i < DEPTH; i++) push_word(32'h100 + i, 32'h0);
      rd(A_STS, d); check("R6 zero credits", {55'd0, d[8:0]}, 64'd0);
      wr(A_DATA, 64'h0000_0000_0BAD_0BAD);
      rd(A_ERR, d); check("R6 overflow bit", d, 64'h10);
      drain("R6 extra word dropped");
      wr(A_ERR, 64'h10);
      rd(A_ERR, d); check("R9 w1c ovf", d, 64'd0);
   endtask

   task automatic t_protocol_and_done();
      logic [63:0] d;
      engine_reset();
      wr(A_DATA, 64'h5555);
      rd(A_ERR, d); check("R7 write before start", d, 64'h8);
      rd(A_STS, d); check("R7 no entry used", {55'd0, d[8:0]}, DEPTH);
      wr(A_ERR, 64'h8);
      wr(A_CTRL, 64'h1000);
      push_word(32'h7777_0001, 32'h0);
      push_word(32'h7777_0002, 32'h0);
      wr(A_CTRL, 64'h3000);
      for (int i = 0; i < 4; i++) @(negedge clk);
      rd(A_CTRL, d);
      check("R8 start held while queued", {62'd0, d[13:12]}, 64'd3);
      wr(A_DATA, 64'h9999);
      rd(A_ERR, d); check("R7 write after complete", d, 64'h8);
      drain("R8 drain");
      @(negedge clk);
      rd(A_CTRL, d);
      check("R8 start/complete cleared", {62'd0, d[13:12]}, 64'd0);
      rd(A_STS, d); check("R10 busy from error", {63'd0, d[16]}, 64'd1);
      wr(A_ERR, 64'h1F);
      rd(A_STS, d); check("R10 idle", {63'd0, d[16]}, 64'd0);
   endtask

   task automatic t_err_inputs();
      logic [63:0] d;
      @(negedge clk); crc_err_in = 1'b1; incompat_err_in = 1'b1;
      @(negedge clk); crc_err_in = 1'b0; incompat_err_in = 1'b0;
      for (int i = 0; i < 3; i++) @(negedge clk);
      rd(A_ERR, d); check("R9 sticky crc/incompat", d, 64'h6);
      wr(A_ERR, 64'h2);
      rd(A_ERR, d); check("R9 w1c single bit", d, 64'h4);
      @(negedge clk); op_err_in = 1'b1;
      @(negedge clk); op_err_in = 1'b0;
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = A_ERR; reg_wr_data = 64'h1; op_err_in = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0; op_err_in = 1'b0;
      rd(A_ERR, d); check("R9 set wins over clear", d, 64'h5);
      wr(A_ERR, 64'h5);
      rd(A_ERR, d); check("R9 all cleared", d, 64'h0);
   endtask

   task automatic t_id_regs();
      logic [63:0] d;
      wr(A_IDH, 64'h0); wr(A_IDL, 64'h0); wr(A_HDR, 64'h0);
      rd(A_IDH, d); check("R11 id hi", d, IDH);
      rd(A_IDL, d); check("R11 id lo", d, IDL);
      rd(A_HDR, d); check("R11 header", d, HDRV);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_push_drain();
      t_overflow();
      t_protocol_and_done();
      t_err_inputs();
      t_id_regs();
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule